// File: doc/BRIEF.md
# Aligned Interrupt Vector Allocator

This block hands out groups of message-signalled interrupt vectors from a pool of 64, keeping one occupancy bit for each vector. A requester asks for N vectors. The block rounds N up to the next power of two. It then claims the lowest free group of that size whose first index is a multiple of the size, and returns that first index. The caller uses the index as the base message data value. Because a group always starts on a multiple of its own size, an endpoint that varies the low data bits of its message stays inside its own group and cannot reach another endpoint's vectors.

A request is accepted through a valid/ready handshake. The search tests one aligned candidate per clock, starting from index 0. It ends with a one-cycle response that carries a success flag and the base index. A separate release handshake frees a group, given its base and the original count. Only one operation runs at a time. The occupancy bitmap is visible on an output port.

Top module: `vec_pool_alloc`

## Requirements
- R1: After reset, `occ_map` is all zeros, `rsp_valid` is 0, and both `req_ready` and `rel_ready` are 1 while no valid input is driven.
- R2: A request for N vectors, with 1 <= N <= 32, reserves exactly 2^ceil(log2 N) consecutive vectors. For example, N=3 sets 4 bits in `occ_map` and N=5 sets 8 bits. Bit i of `occ_map` set means vector i is in use.
- R3: The base returned on a successful response is a multiple of the reserved group size.
- R4: Among the aligned groups that are entirely free, the one with the lowest base is chosen. For example, with only vector 0 in use, a request for 2 returns base 2.
- R5: When no aligned group of the needed size is entirely free, the response has `rsp_ok`=0 and `occ_map` is left unchanged. This holds even when enough scattered free vectors exist.
- R6: A request with N=0 or N>32 is rejected with `rsp_ok`=0, leaves `occ_map` unchanged, and is answered in the cycle right after acceptance.
- R7: An accepted release with 1 <= count <= 32 clears the aligned 2^ceil(log2 count) group that contains `rel_base`. The change is visible in the cycle after acceptance. A release with count 0 or count >32 leaves `occ_map` unchanged.
- R8: Operations are serialised. While a request is being processed, both ready outputs are 0. When a request and a release are offered in the same idle cycle, the request is taken and the release is not.
- R9: `rsp_valid` is high for exactly one cycle per accepted request. For a success at base B with group size S, it rises B/S+1 cycles after the acceptance edge. For a failure, it rises 64/S cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request offered |
| req_ready | output | 1 | Allocation request can be taken |
| req_count | input | 7 | Number of vectors wanted |
| rel_valid | input | 1 | Release offered |
| rel_ready | output | 1 | Release can be taken |
| rel_base | input | 6 | Base index of the group to free |
| rel_count | input | 7 | Count the group was allocated with |
| rsp_valid | output | 1 | One-cycle allocation result strobe |
| rsp_ok | output | 1 | 1 = group allocated, 0 = no space or invalid count |
| rsp_base | output | 6 | First vector index of the allocated group |
| occ_map | output | 64 | Occupancy bitmap, bit i = vector i in use |

## Verification
The assertions check several properties on every cycle:
- the response pulse lasts one cycle;
- every successful base is aligned to the rounded size of its own request;
- the claimed bits were clear just before the grant and are set at the grant;
- a failure or an idle cycle never changes the bitmap;
- the block never takes two operations in the same cycle and drops ready while busy.

Some behaviours only the bench's scenarios can show. These are that the lowest free group is the one chosen, the exact latency of each search, the full-pool failure under fragmentation, and the exact group a release clears. The bench shows them by sweeping every count from 1 to 32 against an arithmetic model of the bitmap.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
    localparam int POOL_SIZE = 64;
    localparam int ADDR_W    = $clog2(POOL_SIZE);
    localparam int MAX_ORDER = 5;
    localparam int ORD_W     = $clog2(MAX_ORDER + 1);
    localparam int CNT_W     = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_RESP   = 2'd2
    } vpa_state_e;
endpackage

// File: rtl/vpa_order.sv
module vpa_order #(
    parameter int CNT_W     = 7,
    parameter int MAX_ORDER = 5,
    parameter int ORD_W     = 3
) (
    input  logic [CNT_W-1:0] count,
    output logic [ORD_W-1:0] order,
    output logic             legal
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << MAX_ORDER;

    always_comb begin
        order = '0;
        for (int o = MAX_ORDER; o >= 0; o--) begin
            if (count <= (CNT_W'(1) << o)) begin
                order = ORD_W'(o);
            end
        end
        legal = (count != '0) && (count <= LIMIT);
    end
endmodule

// File: rtl/vpa_region_mask.sv
module vpa_region_mask #(
    parameter int POOL_SIZE = 64,
    parameter int ADDR_W    = 6,
    parameter int ORD_W     = 3
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [ORD_W-1:0]     order,
    output logic [POOL_SIZE-1:0] mask
);
    for (genvar g = 0; g < POOL_SIZE; g++) begin : g_bit
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        assign mask[g] = ((IDX >> order) == (base >> order));
    end
endmodule

// File: rtl/vec_pool_alloc.sv
module vec_pool_alloc
    import vpa_pkg::*;
#(
    parameter int P_POOL  = POOL_SIZE,
    parameter int P_ADDRW = ADDR_W,
    parameter int P_MAXO  = MAX_ORDER,
    parameter int P_ORDW  = ORD_W,
    parameter int P_CNTW  = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [P_CNTW-1:0]  req_count,
    input  logic               rel_valid,
    output logic               rel_ready,
    input  logic [P_ADDRW-1:0] rel_base,
    input  logic [P_CNTW-1:0]  rel_count,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [P_ADDRW-1:0] rsp_base,
    output logic [P_POOL-1:0]  occ_map
);
    typedef struct packed {
        vpa_state_e         st;
        logic [P_ADDRW-1:0] cand;
        logic [P_ORDW-1:0]  ord;
        logic [P_POOL-1:0]  occ;
        logic               rsp_valid;
        logic               rsp_ok;
        logic [P_ADDRW-1:0] rsp_base;
    } vpa_regs_t;

    vpa_regs_t d, q;

    logic [P_ORDW-1:0]  req_ord, rel_ord;
    logic               req_legal, rel_legal;
    logic [P_POOL-1:0]  cand_mask, rel_mask;
    logic [P_ADDRW:0]   cand_next;

    vpa_order #(.CNT_W(P_CNTW), .MAX_ORDER(P_MAXO), .ORD_W(P_ORDW)) u_req_ord (
        .count(req_count), .order(req_ord), .legal(req_legal)
    );

    vpa_order #(.CNT_W(P_CNTW), .MAX_ORDER(P_MAXO), .ORD_W(P_ORDW)) u_rel_ord (
        .count(rel_count), .order(rel_ord), .legal(rel_legal)
    );

    vpa_region_mask #(.POOL_SIZE(P_POOL), .ADDR_W(P_ADDRW), .ORD_W(P_ORDW)) u_cand_mask (
        .base(q.cand), .order(q.ord), .mask(cand_mask)
    );

    vpa_region_mask #(.POOL_SIZE(P_POOL), .ADDR_W(P_ADDRW), .ORD_W(P_ORDW)) u_rel_mask (
        .base(rel_base), .order(rel_ord), .mask(rel_mask)
    );

    // next aligned candidate; the carry bit marks the end of the pool
    assign cand_next = {1'b0, q.cand} + ((P_ADDRW+1)'(1) << q.ord);

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_legal) begin
                        d.st   = ST_SEARCH;
                        d.ord  = req_ord;
                        d.cand = '0;
                    end else begin
                        d.st        = ST_RESP;
                        d.rsp_valid = 1'b1;
                        d.rsp_ok    = 1'b0;
                        d.rsp_base  = '0;
                    end
                end else if (rel_valid && rel_legal) begin
                    d.occ = q.occ & ~rel_mask;
                end
            end
            ST_SEARCH: begin
                if ((q.occ & cand_mask) == '0) begin
                    d.occ       = q.occ | cand_mask;
                    d.st        = ST_RESP;
                    d.rsp_valid = 1'b1;
                    d.rsp_ok    = 1'b1;
                    d.rsp_base  = q.cand;
                end else if (cand_next[P_ADDRW]) begin
                    d.st        = ST_RESP;
                    d.rsp_valid = 1'b1;
                    d.rsp_ok    = 1'b0;
                    d.rsp_base  = '0;
                end else begin
                    d.cand = cand_next[P_ADDRW-1:0];
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.cand      <= '0;
            q.ord       <= '0;
            q.occ       <= '0;
            q.rsp_valid <= 1'b0;
            q.rsp_ok    <= 1'b0;
            q.rsp_base  <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rel_ready = (q.st == ST_IDLE) && !req_valid;
    assign rsp_valid = q.rsp_valid;
    assign rsp_ok    = q.rsp_ok;
    assign rsp_base  = q.rsp_base;
    assign occ_map   = q.occ;
endmodule

// File: rtl/vpa_checker.sv
module vpa_checker #(
    parameter int P_POOL  = 64,
    parameter int P_ADDRW = 6,
    parameter int P_CNTW  = 7,
    parameter int P_MAXN  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [P_CNTW-1:0]  req_count,
    input logic               rel_valid,
    input logic               rel_ready,
    input logic               rsp_valid,
    input logic               rsp_ok,
    input logic [P_ADDRW-1:0] rsp_base,
    input logic [P_POOL-1:0]  occ_map
);
    function automatic int round_size(input int n);
        int s;
        s = 1;
        while (s < n) s = s * 2;
        return s;
    endfunction

    int size_q;
    logic [P_POOL-1:0] grp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= 1;
        end else if (req_valid && req_ready) begin
            size_q <= round_size(int'(req_count));
        end
    end

    always_comb begin
        for (int i = 0; i < P_POOL; i++) begin
            grp[i] = (i >= int'(rsp_base)) && (i < int'(rsp_base) + size_q);
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> ((int'(rsp_base) % size_q) == 0)); // R3
    AST_GROUP_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (((occ_map & grp) == grp) && (($past(occ_map) & grp) == '0))); // R2
    AST_FAIL_MAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> $stable(occ_map)); // R5
    AST_INVALID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ((req_count == '0) || (int'(req_count) > P_MAXN)))
        |=> (rsp_valid && !rsp_ok)); // R6
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && rel_valid && rel_ready)); // R8
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rel_ready)); // R8
    AST_MAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rel_valid && rel_ready) && !(rsp_valid && rsp_ok)) |-> $stable(occ_map)); // R7
endmodule

bind vec_pool_alloc vpa_checker #(
    .P_POOL(P_POOL), .P_ADDRW(P_ADDRW), .P_CNTW(P_CNTW), .P_MAXN(1 << P_MAXO)
) u_vpa_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_count(req_count), .rel_valid(rel_valid), .rel_ready(rel_ready),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_base(rsp_base), .occ_map(occ_map)
);

// File: tb/tb_vec_pool_alloc.sv
`timescale 1ns/1ps
module tb_vec_pool_alloc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_count = '0;
    logic        rel_valid = 1'b0;
    logic        rel_ready;
    logic [5:0]  rel_base = '0;
    logic [6:0]  rel_count = '0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [5:0]  rsp_base;
    logic [63:0] occ_map;

    logic [63:0] model = '0;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    vec_pool_alloc dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_count(req_count),
        .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_base(rel_base), .rel_count(rel_count),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_base(rsp_base), .occ_map(occ_map)
    );

    task automatic chk(input bit cond, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int gsize(input int n);
        int s;
        s = 1;
        while (s < n) s = s * 2;
        return s;
    endfunction

    function automatic logic [63:0] gmask(input int b, input int s);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < s; i++) m[b + i] = 1'b1;
        return m;
    endfunction

    // request N vectors, optionally offering a release in the same cycle
    task automatic do_alloc(input int n, input string rq, input bit also_rel);
        int s, eb, elat, lat;
        bit eok;
        eok = 0; eb = 0; s = 1; elat = 0;
        if (n >= 1 && n <= 32) begin
            s = gsize(n);
            for (int b = 0; b < 64; b += s) begin
                if (!eok && ((model & gmask(b, s)) == '0)) begin
                    eok = 1; eb = b;
                end
            end
            elat = eok ? (eb / s + 1) : (64 / s);
        end
        req_valid = 1'b1;
        req_count = 7'(n);
        if (also_rel) begin
            rel_valid = 1'b1; rel_base = 6'd0; rel_count = 7'd1;
            #0.1;
            chk(rel_ready == 1'b0, "R8", "rel_ready with request offered", 64'(rel_ready), 64'd0);
        end
        #0.1;
        chk(req_ready == 1'b1, rq, "req_ready idle", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rel_valid = 1'b0;
        chk(req_ready == 1'b0, "R8", "req_ready while busy", 64'(req_ready), 64'd0);
        lat = 0;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == elat, (n < 1 || n > 32) ? "R6" : "R9", "response latency", 64'(lat), 64'(elat));
        chk(rsp_ok == eok, eok ? rq : "R5", "rsp_ok", 64'(rsp_ok), 64'(eok));
        if (eok) begin
            chk(rsp_base == 6'(eb), "R4", "rsp_base", 64'(rsp_base), 64'(eb));
            model = model | gmask(eb, s);
        end
        chk(occ_map == model, eok ? "R2" : "R5", "occ_map after request", occ_map, model);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_free(input int b, input int n);
        rel_valid = 1'b1;
        rel_base  = 6'(b);
        rel_count = 7'(n);
        #0.1;
        chk(rel_ready == 1'b1, "R8", "rel_ready idle", 64'(rel_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
        if (n >= 1 && n <= 32) model = model & ~gmask(b, gsize(n));
        chk(occ_map == model, "R7", "occ_map after release", occ_map, model);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R1 reset state
        chk(occ_map == '0, "R1", "occ_map after reset", occ_map, 64'd0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(rel_ready == 1'b1, "R1", "rel_ready after reset", 64'(rel_ready), 64'd1);
        @(negedge clk);

        // R2 R3 R4 R5: fill the pool with every count, then empty it
        for (int n = 1; n <= 32; n++) begin
            int s;
            s = gsize(n);
            for (int k = 0; k <= 64 / s; k++) do_alloc(n, "R3", 1'b0);
            for (int b = 0; b < 64; b += s) do_free(b, n);
        end

        // R4: lowest aligned free group
        do_alloc(1, "R4", 1'b0);   // base 0
        do_alloc(2, "R4", 1'b0);   // base 2, not 1
        do_alloc(1, "R4", 1'b0);   // base 1
        do_alloc(3, "R4", 1'b0);   // base 4, 4 bits
        do_free(2, 2);
        do_alloc(2, "R4", 1'b0);   // base 2 again

        // R6: illegal counts
        do_alloc(0, "R6", 1'b0);
        do_alloc(33, "R6", 1'b0);
        do_alloc(127, "R6", 1'b0);

        // R7: illegal release counts leave the map alone
        do_free(0, 0);
        do_free(4, 40);

        // R8: request wins over a release offered together (vector 0 stays in use)
        do_alloc(1, "R8", 1'b1);
        chk(occ_map[0] == 1'b1, "R8", "release not taken", 64'(occ_map[0]), 64'd1);

        // R5: fragmented pool, every even vector in use
        for (int b = 0; b < 64; b++) if (model[b]) do_free(b, 1);
        for (int k = 0; k < 64; k++) do_alloc(1, "R2", 1'b0);
        for (int b = 1; b < 64; b += 2) do_free(b, 1);
        do_alloc(2, "R5", 1'b0);
        do_alloc(1, "R4", 1'b0);   // base 1

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule